// File: doc/BRIEF.md
# Dual-Source DMA Command Queue Splitter

This block is the command side of a data-movement engine that sits next to a compute core and works on its own. Two producers hand it block-transfer commands: the core beside it and a remote port reached through memory-mapped writes. Each producer has a private queue of its own depth. A command names a local-memory address, a system address, a byte count, a direction and a 5-bit tag.

The engine takes commands from the two queues in turn, one whole command at a time. It cuts each command into bus requests that never cross a 128-byte line of the system address. A request goes out only in a cycle where the bus token input is high, and no more than 16 requests may wait for an acknowledge at once. Acknowledges come back in issue order. When the final piece of the final pending command with a given tag is acknowledged, the bit for that tag in a 32-bit done vector turns on. The producer side only enqueues commands and polls that vector.

Top module: `dma_cmd_splitter`

## Requirements
- R1: The local queue holds 16 waiting commands and the remote queue holds 8, not counting the one command being split. A producer's ready output is low exactly while its queue is full, and a command is taken only in a cycle with valid and ready both high.
- R2: A command whose length is 0 or above 16384 bytes is not queued and produces no bus request. Its producer's error output is high for the one cycle after the cycle it was offered with ready high. A length of exactly 16384 is accepted.
- R3: Each piece covers the bytes from the current system address to the next 128-byte boundary, or to the end of the command if that comes first. The local and system addresses both advance by the size of each piece. So an unaligned command gives a short leading piece, then full 128-byte pieces, then a short trailing piece.
- R4: Commands from one queue are split in arrival order. When both queues hold commands, the engine alternates between them one command at a time. After reset the local queue is served first.
- R5: At most 16 requests are unacknowledged at any time. While 16 are outstanding, the request output stays low until an acknowledge arrives.
- R6: A request is transferred only in a cycle where the request output and the token input are both high. While the token is low, the pending request and its fields stay unchanged.
- R7: Each acknowledge retires the oldest outstanding request. Bit t of the done vector sets when the last piece of the last pending command with tag t is acknowledged. It stays low while any other queued, active or unacknowledged command still carries tag t.
- R8: Accepting a command with tag t clears bit t of the done vector. A rejected command leaves the vector unchanged.
- R9: After reset both ready outputs are high, the request and error outputs are low, and the done vector is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_valid | input | 1 | Local producer offers a command |
| loc_ready | output | 1 | Local queue has room |
| loc_lsa | input | 18 | Local-memory address of the local command |
| loc_sys | input | 32 | System address of the local command |
| loc_len | input | 15 | Byte count of the local command |
| loc_dir | input | 1 | Direction of the local command |
| loc_tag | input | 5 | Tag of the local command |
| loc_err | output | 1 | One-cycle pulse: local command rejected |
| rem_valid | input | 1 | Remote port offers a command |
| rem_ready | output | 1 | Remote queue has room |
| rem_lsa | input | 18 | Local-memory address of the remote command |
| rem_sys | input | 32 | System address of the remote command |
| rem_len | input | 15 | Byte count of the remote command |
| rem_dir | input | 1 | Direction of the remote command |
| rem_tag | input | 5 | Tag of the remote command |
| rem_err | output | 1 | One-cycle pulse: remote command rejected |
| bus_tok | input | 1 | Bus access token held this cycle |
| bus_req | output | 1 | A request piece is pending |
| bus_lsa | output | 18 | Local-memory address of the piece |
| bus_sys | output | 32 | System address of the piece |
| bus_len | output | 8 | Byte count of the piece, 1 to 128 |
| bus_dir | output | 1 | Direction of the piece |
| bus_tag | output | 5 | Tag of the piece |
| bus_ack | input | 1 | Oldest outstanding request acknowledged |
| tag_done | output | 32 | Per-tag completion bits |

## Verification
The hardest case to reach is a tag shared by two commands from different queues whose pieces finish at different times. The done bit must stay low after the first command's final acknowledge and rise only after the second command's final acknowledge. The bench holds acknowledges off until all three pieces are out, then releases them one at a time through a budget. Reaching full queues in a known alternation order is just as awkward. Here the bench holds the token low while it fills both queues, so the whole issue sequence can be predicted before any piece leaves.

// File: rtl/dma_cmd_splitter.sv
module dma_cmd_splitter #(
  parameter int LSA_W    = 18,
  parameter int SYS_W    = 32,
  parameter int LEN_W    = 15,
  parameter int TAG_W    = 5,
  parameter int LQ_DEPTH = 16,
  parameter int RQ_DEPTH = 8,
  parameter int LINE_B   = 128,
  parameter int MAX_OUT  = 16,
  parameter int MAX_LEN  = 16384
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    loc_valid,
  output logic                    loc_ready,
  input  logic [LSA_W-1:0]        loc_lsa,
  input  logic [SYS_W-1:0]        loc_sys,
  input  logic [LEN_W-1:0]        loc_len,
  input  logic                    loc_dir,
  input  logic [TAG_W-1:0]        loc_tag,
  output logic                    loc_err,
  input  logic                    rem_valid,
  output logic                    rem_ready,
  input  logic [LSA_W-1:0]        rem_lsa,
  input  logic [SYS_W-1:0]        rem_sys,
  input  logic [LEN_W-1:0]        rem_len,
  input  logic                    rem_dir,
  input  logic [TAG_W-1:0]        rem_tag,
  output logic                    rem_err,
  input  logic                    bus_tok,
  output logic                    bus_req,
  output logic [LSA_W-1:0]        bus_lsa,
  output logic [SYS_W-1:0]        bus_sys,
  output logic [$clog2(LINE_B):0] bus_len,
  output logic                    bus_dir,
  output logic [TAG_W-1:0]        bus_tag,
  input  logic                    bus_ack,
  output logic [(1<<TAG_W)-1:0]   tag_done
);
  localparam int OFF_W = $clog2(LINE_B);
  localparam int PW    = OFF_W + 1;
  localparam int NTAG  = 1 << TAG_W;
  localparam int CW    = LSA_W + SYS_W + LEN_W + 1 + TAG_W;
  localparam int OC_W  = $clog2(MAX_OUT + 1);
  localparam int CA_W  = $clog2(MAX_OUT);
  localparam int TC_W  = $clog2(LQ_DEPTH + RQ_DEPTH + 4) + 1;

  logic [1:0]    in_valid, in_ready, push, pop, nonempty;
  logic [CW-1:0] in_cmd [2];
  logic [CW-1:0] q_head [2];
  logic          sel, take, rr_last, act, issue, last_pc, fin;
  logic [CW-1:0] hd;
  logic [LSA_W-1:0] a_lsa;
  logic [SYS_W-1:0] a_sys;
  logic [LEN_W-1:0] a_rem;
  logic             a_dir;
  logic [TAG_W-1:0] a_tag, fin_tag;
  logic [OFF_W-1:0] off;
  logic [PW-1:0]    room, piece;
  logic [OC_W-1:0]  out_cnt;
  logic [TAG_W:0]   cq [MAX_OUT];
  logic [CA_W-1:0]  cwp, crp;

  assign in_valid  = {rem_valid, loc_valid};
  assign in_cmd[0] = {loc_lsa, loc_sys, loc_len, loc_dir, loc_tag};
  assign in_cmd[1] = {rem_lsa, rem_sys, rem_len, rem_dir, rem_tag};

  for (genvar s = 0; s < 2; s++) begin : g_q
    localparam int D  = (s == 0) ? LQ_DEPTH : RQ_DEPTH;
    localparam int AW = (D > 1) ? $clog2(D) : 1;
    logic [CW-1:0]    mem [D];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic [LEN_W-1:0] len;
    logic             ok, err;

    assign len         = in_cmd[s][TAG_W+1 +: LEN_W];
    assign ok          = (len != '0) && (int'(len) <= MAX_LEN);
    assign in_ready[s] = cnt < (AW+1)'(D);
    assign push[s]     = in_valid[s] && in_ready[s] && ok;
    assign nonempty[s] = cnt != '0;
    assign q_head[s]   = mem[rp];

    always_ff @(posedge clk) if (push[s]) mem[wp] <= in_cmd[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp <= '0; rp <= '0; cnt <= '0; err <= 1'b0;
      end else begin
        err <= in_valid[s] && in_ready[s] && !ok;
        if (push[s]) wp <= (wp == AW'(D-1)) ? '0 : wp + 1'b1;
        if (pop[s])  rp <= (rp == AW'(D-1)) ? '0 : rp + 1'b1;
        cnt <= cnt + (AW+1)'(push[s]) - (AW+1)'(pop[s]);
      end
    end

    p_q_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (AW+1)'(D));
    p_err_not_queued_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[s] && in_ready[s] && !ok |=> cnt <= $past(cnt) && err);
  end

  assign loc_ready = in_ready[0];
  assign rem_ready = in_ready[1];
  assign loc_err   = g_q[0].err;
  assign rem_err   = g_q[1].err;

  assign sel  = (nonempty == 2'b11) ? ~rr_last : nonempty[1];
  assign take = !act && (nonempty != 2'b00);
  assign pop  = {take & sel, take & ~sel};
  assign hd   = q_head[sel];

  assign off     = a_sys[OFF_W-1:0];
  assign room    = PW'(LINE_B) - PW'(off);
  assign last_pc = a_rem <= LEN_W'(room);
  assign piece   = last_pc ? PW'(a_rem) : room;
  assign bus_req = act && (out_cnt < OC_W'(MAX_OUT));
  assign issue   = bus_req && bus_tok;
  assign bus_lsa = a_lsa;
  assign bus_sys = a_sys;
  assign bus_len = piece;
  assign bus_dir = a_dir;
  assign bus_tag = a_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; rr_last <= 1'b1;
      a_lsa <= '0; a_sys <= '0; a_rem <= '0; a_dir <= 1'b0; a_tag <= '0;
    end else if (take) begin
      act     <= 1'b1;
      rr_last <= sel;
      {a_lsa, a_sys, a_rem, a_dir, a_tag} <= hd;
    end else if (issue) begin
      a_lsa <= a_lsa + LSA_W'(piece);
      a_sys <= a_sys + SYS_W'(piece);
      a_rem <= a_rem - LEN_W'(piece);
      if (last_pc) act <= 1'b0;
    end
  end

  assign fin     = bus_ack && cq[crp][TAG_W];
  assign fin_tag = cq[crp][TAG_W-1:0];

  always_ff @(posedge clk) if (issue) cq[cwp] <= {last_pc, a_tag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0; crp <= '0; out_cnt <= '0;
    end else begin
      if (issue)   cwp <= (cwp == CA_W'(MAX_OUT-1)) ? '0 : cwp + 1'b1;
      if (bus_ack) crp <= (crp == CA_W'(MAX_OUT-1)) ? '0 : crp + 1'b1;
      out_cnt <= out_cnt + OC_W'(issue) - OC_W'(bus_ack);
    end
  end

  p_out_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OC_W'(MAX_OUT));
  p_hold_no_tok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_tok |=> bus_req && $stable(bus_sys) && $stable(bus_lsa)
                            && $stable(bus_len) && $stable(bus_tag));
  p_piece_in_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_len != '0 && (int'(bus_sys[OFF_W-1:0]) + int'(bus_len)) <= LINE_B);

  for (genvar t = 0; t < NTAG; t++) begin : g_tag
    logic [TC_W-1:0] pend;
    logic [1:0]      inc;
    logic            dec, done;

    assign inc = {1'b0, push[0] && (loc_tag == TAG_W'(t))}
               + {1'b0, push[1] && (rem_tag == TAG_W'(t))};
    assign dec = fin && (fin_tag == TAG_W'(t));
    assign tag_done[t] = done;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend <= '0; done <= 1'b0;
      end else begin
        pend <= pend + TC_W'(inc) - TC_W'(dec);
        if (inc != 2'd0) done <= 1'b0;
        else if (dec && pend == TC_W'(1)) done <= 1'b1;
      end
    end

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> pend == '0);
  end
endmodule

// File: tb/dma_cmd_splitter_tb.sv
module dma_cmd_splitter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic loc_valid = 0, rem_valid = 0, loc_dir = 0, rem_dir = 0;
  logic [17:0] loc_lsa = 0, rem_lsa = 0;
  logic [31:0] loc_sys = 0, rem_sys = 0;
  logic [14:0] loc_len = 0, rem_len = 0;
  logic [4:0]  loc_tag = 0, rem_tag = 0;
  logic loc_ready, rem_ready, loc_err, rem_err, bus_req, bus_dir, bus_tok, bus_ack = 0;
  logic [17:0] bus_lsa;
  logic [31:0] bus_sys;
  logic [7:0]  bus_len;
  logic [4:0]  bus_tag;
  logic [31:0] tag_done;
  logic tok_en = 0, ack_en = 1;
  int ack_budget = 0, pend = 0, issued = 0, nchk = 0, nfail = 0;
  logic [63:0] exp_q[$];

  assign bus_tok = tok_en;
  always #5 clk = ~clk;

  dma_cmd_splitter u_dut (
    .clk, .rst_n,
    .loc_valid, .loc_ready, .loc_lsa, .loc_sys, .loc_len, .loc_dir, .loc_tag, .loc_err,
    .rem_valid, .rem_ready, .rem_lsa, .rem_sys, .rem_len, .rem_dir, .rem_tag, .rem_err,
    .bus_tok, .bus_req, .bus_lsa, .bus_sys, .bus_len, .bus_dir, .bus_tag, .bus_ack, .tag_done
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [17:0] lsa, input logic [31:0] sys,
                            input int len, input logic dir, input logic [4:0] tag);
    int rem = len;
    while (rem > 0) begin
      int room = 128 - int'(sys[6:0]);
      int sz = (rem < room) ? rem : room;
      exp_q.push_back({lsa, sys, 8'(sz), dir, tag});
      lsa = lsa + 18'(sz);
      sys = sys + 32'(sz);
      rem = rem - sz;
    end
  endtask

  task automatic send(input bit src, input logic [17:0] lsa, input logic [31:0] sys,
                      input int len, input logic dir, input logic [4:0] tag);
    if (!src) begin
      loc_lsa = lsa; loc_sys = sys; loc_len = 15'(len); loc_dir = dir; loc_tag = tag;
      loc_valid = 1;
      while (!loc_ready) @(negedge clk);
      @(negedge clk);
      loc_valid = 0;
    end else begin
      rem_lsa = lsa; rem_sys = sys; rem_len = 15'(len); rem_dir = dir; rem_tag = tag;
      rem_valid = 1;
      while (!rem_ready) @(negedge clk);
      @(negedge clk);
      rem_valid = 0;
    end
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || pend != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor and acknowledge driver
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit ak;
      ak = (pend > 0) && (ack_en || ack_budget > 0);
      bus_ack = ak;
      if (ak) begin
        pend--;
        if (!ack_en) ack_budget--;
      end
      if (bus_req && bus_tok) begin
        issued++;
        pend++;
        if (exp_q.size() == 0)
          check(0, "R2 R6 unexpected piece", {bus_lsa, bus_sys, bus_len, bus_dir, bus_tag}, 0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check({bus_lsa, bus_sys, bus_len, bus_dir, bus_tag} == e, "R3 R4 piece",
                {bus_lsa, bus_sys, bus_len, bus_dir, bus_tag}, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog act 0 exp 1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(loc_ready && rem_ready, "R9 ready", {loc_ready, rem_ready}, 2'b11);
    check(!bus_req && !loc_err && !rem_err, "R9 req/err", {bus_req, loc_err, rem_err}, 0);
    check(tag_done == 0, "R9 tag_done", tag_done, 0);

    // R3 unaligned command: 75 + 128 + 97
    tok_en = 1;
    expect_cmd(18'h00105, 32'h1000_0035, 300, 0, 5'd1);
    send(0, 18'h00105, 32'h1000_0035, 300, 0, 5'd1);
    wait_idle();
    check(tag_done[1], "R7 tag1 done", tag_done[1], 1);

    // R2 rejections, R8 rejected leaves vector
    send(0, 18'h0, 32'h0, 0, 0, 5'd1);
    check(loc_err, "R2 zero length err", loc_err, 1);
    @(negedge clk);
    check(!loc_err, "R2 err one cycle", loc_err, 0);
    send(1, 18'h0, 32'h0, 16385, 1, 5'd1);
    check(rem_err, "R2 oversize err", rem_err, 1);
    repeat (10) @(negedge clk);
    check(!bus_req && tag_done[1], "R8 rejected keeps done", {bus_req, tag_done[1]}, 1);

    // R8 clear on accept, R6 token gating
    tok_en = 0;
    expect_cmd(18'h00200, 32'h1100_0000, 256, 1, 5'd1);
    send(0, 18'h00200, 32'h1100_0000, 256, 1, 5'd1);
    check(!tag_done[1], "R8 cleared on accept", tag_done[1], 0);
    base = issued;
    repeat (20) @(negedge clk);
    check(bus_req && issued == base, "R6 no issue without token", {bus_req, 32'(issued - base)}, 64'h1_0000_0000);
    tok_en = 1;
    wait_idle();
    check(tag_done[1], "R7 tag1 done again", tag_done[1], 1);

    // R5 outstanding cap
    ack_en = 0;
    base = issued;
    expect_cmd(18'h01000, 32'h4000_0000, 4096, 0, 5'd12);
    send(0, 18'h01000, 32'h4000_0000, 4096, 0, 5'd12);
    repeat (60) @(negedge clk);
    check(issued - base == 16, "R5 cap 16", issued - base, 16);
    check(!bus_req, "R5 req low at cap", bus_req, 0);
    ack_en = 1;
    wait_idle();
    check(tag_done[12], "R7 tag12 done", tag_done[12], 1);

    // R1 full queues, R4 alternation
    tok_en = 0;
    for (int i = 0; i < 17; i++) send(0, 18'(i * 128), 32'h2000_0000 + 32'(i * 256), 64, 0, 5'(i));
    check(!loc_ready, "R1 local full", loc_ready, 0);
    for (int i = 0; i < 8; i++) send(1, 18'h10000 + 18'(i * 128), 32'h3000_0000 + 32'(i * 256), 64, 1, 5'(20 + i));
    check(!rem_ready, "R1 remote full", rem_ready, 0);
    expect_cmd(18'h0, 32'h2000_0000, 64, 0, 5'd0);
    for (int k = 0; k < 8; k++) begin
      expect_cmd(18'h10000 + 18'(k * 128), 32'h3000_0000 + 32'(k * 256), 64, 1, 5'(20 + k));
      expect_cmd(18'((k + 1) * 128), 32'h2000_0000 + 32'((k + 1) * 256), 64, 0, 5'(k + 1));
    end
    for (int i = 9; i < 17; i++) expect_cmd(18'(i * 128), 32'h2000_0000 + 32'(i * 256), 64, 0, 5'(i));
    tok_en = 1;
    wait_idle();
    check((tag_done & 32'h0FF1_FFFF) == 32'h0FF1_FFFF, "R7 all tags done", tag_done, 32'h0FF1_FFFF);
    check(loc_ready && rem_ready, "R1 ready after drain", {loc_ready, rem_ready}, 2'b11);

    // R7 shared tag across queues
    ack_en = 0;
    base = issued;
    expect_cmd(18'h02000, 32'h5000_0000, 128, 0, 5'd9);
    expect_cmd(18'h03000, 32'h5100_0000, 256, 1, 5'd9);
    send(0, 18'h02000, 32'h5000_0000, 128, 0, 5'd9);
    send(1, 18'h03000, 32'h5100_0000, 256, 1, 5'd9);
    check(!tag_done[9], "R8 tag9 cleared", tag_done[9], 0);
    while (issued - base < 3) @(negedge clk);
    ack_budget = 1;
    repeat (5) @(negedge clk);
    check(!tag_done[9], "R7 tag9 still pending", tag_done[9], 0);
    ack_budget = 2;
    repeat (5) @(negedge clk);
    check(tag_done[9], "R7 tag9 done", tag_done[9], 1);
    ack_en = 1;

    // R2 max length accepted, R3 odd offset
    expect_cmd(18'h04000, 32'h6000_007F, 16384, 1, 5'd30);
    send(1, 18'h04000, 32'h6000_007F, 16384, 1, 5'd30);
    check(!rem_err, "R2 16384 accepted", rem_err, 0);
    wait_idle();
    check(tag_done[30], "R7 tag30 done", tag_done[30], 1);

    // R3 small pieces
    expect_cmd(18'h05000, 32'h7000_0010, 5, 0, 5'd31);
    expect_cmd(18'h05100, 32'h7000_0140, 128, 0, 5'd31);
    send(0, 18'h05000, 32'h7000_0010, 5, 0, 5'd31);
    send(0, 18'h05100, 32'h7000_0140, 128, 0, 5'd31);
    wait_idle();
    check(tag_done[31], "R7 tag31 done", tag_done[31], 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule